// File: doc/BRIEF.md
# Two-Level Trigger Latency Buffer

This block holds one front-end data word for every bunch crossing in a circular pipeline. When a first-level (L0) trigger arrives, the block picks the word that was stored a programmed number of crossings earlier. It gives that word the next value of a wrapping event identifier and files it in a small slotted event store. The L0 path has a fixed latency: the word is chosen and filed in the cycle the trigger arrives.

The second stage has no fixed latency. Later, an L1 or R3 request carries an identifier. The block searches the event store for a slot with that identifier and returns the event through an output register with a valid/ready handshake. When no slot matches, the block returns an empty event with an error flag. A slot becomes free once its event has been taken at the output. When every slot is busy, an arriving L0 is dropped and a sticky overflow flag is set.

The pipeline depth must be a power of two and the event store must have at least two slots.

Top module: `trig_latency_buf`

## Requirements
- R1: After reset, `ev_valid_o` and `ovf_o` are 0 and `req_ready_o` is 1.
- R2: The pipeline write position advances by one, and `hit_data_i` is stored, only in cycles where `bc_i` is 1. Cycles without `bc_i` neither store nor advance.
- R3: Let N be the number of `bc_i` strobes taken before an L0 cycle, and L the current latency. An L0 in that cycle files the word stored at strobe N−L, counted modulo the depth. A latency of 0 selects the word from exactly depth strobes before, which is the entry about to be overwritten. The read sees the pipeline as it was before any write in the same cycle.
- R4: A latency write (`lat_we_i`) with a value equal to or above the pipeline depth is ignored, and the previous latency stays in force. After reset the latency is the `LAT_RST` parameter.
- R5: The event identifier starts at 0 after reset. It increments, modulo 2^`ID_W`, on every L0, including dropped ones. Each filed event carries the identifier value from its L0 cycle.
- R6: An L0 that arrives while all slots are in use is dropped and sets `ovf_o`. `ovf_o` stays set until reset.
- R7: A request is taken when `req_valid_i` and `req_ready_o` are both 1. In the next cycle `ev_valid_o` is 1, `ev_id_o` holds the requested identifier, `ev_kind_o` echoes `req_kind_i` (0 = L1, 1 = R3), and a matching slot's word appears on `ev_data_o` with `ev_err_o` at 0.
- R8: A request whose identifier matches no occupied slot returns `ev_err_o` = 1 with `ev_data_o` = 0.
- R9: The matched slot is freed on the cycle the output handshake (`ev_valid_o` and `ev_ready_i`) completes. A repeated request for the same identifier then returns the error response, and the slot can be filled again.
- R10: While `ev_valid_o` is 1, `req_ready_o` is 0. While `ev_ready_i` is low, every output field holds steady.
- R11: New events go into the lowest-numbered free slot. When two occupied slots hold the same identifier, a request returns the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bc_i | input | 1 | Bunch-crossing strobe |
| hit_data_i | input | DATA_W | Front-end word for this crossing |
| lat_we_i | input | 1 | Latency write enable |
| lat_val_i | input | $clog2(PIPE_DEPTH)+1 | Latency value to write |
| l0_i | input | 1 | L0 trigger strobe |
| req_valid_i | input | 1 | L1/R3 request valid |
| req_kind_i | input | 1 | Request kind, 0 = L1, 1 = R3 |
| req_id_i | input | ID_W | Identifier of the wanted event |
| req_ready_o | output | 1 | Request can be taken |
| ev_valid_o | output | 1 | Event output valid |
| ev_ready_i | input | 1 | Consumer takes the event |
| ev_kind_o | output | 1 | Echoed request kind |
| ev_id_o | output | ID_W | Echoed identifier |
| ev_data_o | output | DATA_W | Event word, 0 on error |
| ev_err_o | output | 1 | No matching slot |
| ovf_o | output | 1 | Sticky event-store overflow |

## Verification
The bench builds the block with a depth of 16, four slots, a 3-bit identifier and 16-bit data. With a depth of 16, every legal latency from 0 to 15 can be swept, and the write position wraps many times within a short run. The bench uses each crossing count as its data word, so the expected word is simple arithmetic. The 3-bit identifier wraps after eight L0 triggers. With only four slots, this makes overflow, dropped-but-counted identifiers and duplicate identifiers in two slots reachable within a few dozen cycles.

// File: rtl/tlb_pkg.sv
// Shared types for the two-level trigger latency buffer.
package tlb_pkg;

    // Kind of second-level request; echoed with the returned event.
    typedef enum logic {
        REQ_L1 = 1'b0,
        REQ_R3 = 1'b1
    } req_kind_e;

endpackage

// File: rtl/tlb_pipeline.sv
// Circular sample pipeline with programmable tap latency.
// Stores one word per crossing strobe and presents, combinationally, the
// word stored LAT strobes before the next write position.
// Assumes DEPTH is a power of two, so address arithmetic wraps naturally.
module tlb_pipeline #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 128,
    parameter int LAT_RST = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int LAT_W  = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bc_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              lat_we_i,
    input  logic [LAT_W-1:0]  lat_val_i,
    output logic [DATA_W-1:0] tap_o,
    output logic [LAT_W-1:0]  lat_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q;
    logic [LAT_W-1:0]  lat_q;
    logic [AW-1:0]     rd_addr;

    // Write position: one step per crossing strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) wptr_q <= '0;
        else if (bc_i) wptr_q <= wptr_q + 1'b1;
    end

    // Sample storage: no reset, written at the write position.
    always_ff @(posedge clk) begin
        if (bc_i) mem[wptr_q] <= din_i;
    end

    // Latency register: out-of-range values leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= LAT_W'(LAT_RST);
        else if (lat_we_i && (lat_val_i < LAT_W'(DEPTH))) lat_q <= lat_val_i;
    end

    // Tap address: write position minus latency, modulo depth.
    always_comb begin
        rd_addr = wptr_q - lat_q[AW-1:0];
        tap_o   = mem[rd_addr];
    end

    assign lat_o = lat_q;

endmodule

// File: rtl/tlb_event_store.sv
// Slotted event store indexed by identifier match.
// Allocates the lowest free slot, looks up the lowest occupied slot whose
// identifier matches, and frees a slot by index. Assumes SLOTS >= 2 and
// that a freed slot is never the one being allocated in the same cycle.
module tlb_event_store #(
    parameter int DATA_W = 16,
    parameter int ID_W   = 8,
    parameter int SLOTS  = 16,
    localparam int IW    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ID_W-1:0]   alloc_id_i,
    input  logic [DATA_W-1:0] alloc_data_i,
    output logic              full_o,
    input  logic [ID_W-1:0]   look_id_i,
    output logic              look_hit_o,
    output logic [IW-1:0]     look_idx_o,
    output logic [DATA_W-1:0] look_data_o,
    input  logic              free_i,
    input  logic [IW-1:0]     free_idx_i
);

    logic [SLOTS-1:0]  vld_q;
    logic [SLOTS-1:0]  match;
    logic [ID_W-1:0]   id_q   [SLOTS];
    logic [DATA_W-1:0] data_q [SLOTS];
    logic [IW-1:0]     alloc_idx;
    logic              alloc_fire;

    // Per-slot identifier comparators.
    for (genvar g = 0; g < SLOTS; g++) begin : g_match
        assign match[g] = vld_q[g] && (id_q[g] == look_id_i);
    end

    // Lowest free slot selection.
    always_comb begin
        alloc_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!vld_q[i]) alloc_idx = IW'(i);
        end
    end

    // Lowest matching slot selection.
    always_comb begin
        look_idx_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) look_idx_o = IW'(i);
        end
        look_hit_o  = |match;
        look_data_o = data_q[look_idx_o];
    end

    assign full_o     = &vld_q;
    assign alloc_fire = alloc_i && !full_o;

    // Occupancy: set on allocation, cleared on free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (free_i && (free_idx_i == IW'(i))) vld_q[i] <= 1'b0;
                if (alloc_fire && (alloc_idx == IW'(i))) vld_q[i] <= 1'b1;
            end
        end
    end

    // Slot payload: written only on allocation.
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            id_q[alloc_idx]   <= alloc_id_i;
            data_q[alloc_idx] <= alloc_data_i;
        end
    end

endmodule

// File: rtl/tlb_readout.sv
// Single-entry output stage for second-level requests.
// Takes one request when empty, registers the lookup result (or an empty
// error event), holds it until the consumer accepts, then frees the slot.
module tlb_readout #(
    parameter int DATA_W = 16,
    parameter int ID_W   = 8,
    parameter int IW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_kind_i,
    input  logic [ID_W-1:0]   req_id_i,
    output logic              req_ready_o,
    input  logic              look_hit_i,
    input  logic [IW-1:0]     look_idx_i,
    input  logic [DATA_W-1:0] look_data_i,
    output logic              ev_valid_o,
    input  logic              ev_ready_i,
    output logic              ev_kind_o,
    output logic [ID_W-1:0]   ev_id_o,
    output logic [DATA_W-1:0] ev_data_o,
    output logic              ev_err_o,
    output logic              free_o,
    output logic [IW-1:0]     free_idx_o
);

    logic                valid_q;
    tlb_pkg::req_kind_e  kind_q;
    logic [ID_W-1:0]     id_q;
    logic [DATA_W-1:0]   data_q;
    logic                err_q;
    logic [IW-1:0]       idx_q;
    logic                take;

    assign req_ready_o = !valid_q;
    assign take        = req_valid_i && req_ready_o;

    // Output register: load on request, clear on consumer handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            kind_q  <= tlb_pkg::REQ_L1;
            id_q    <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
            idx_q   <= '0;
        end else if (take) begin
            valid_q <= 1'b1;
            kind_q  <= tlb_pkg::req_kind_e'(req_kind_i);
            id_q    <= req_id_i;
            data_q  <= look_hit_i ? look_data_i : '0;
            err_q   <= !look_hit_i;
            idx_q   <= look_idx_i;
        end else if (valid_q && ev_ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign ev_valid_o = valid_q;
    assign ev_kind_o  = kind_q;
    assign ev_id_o    = id_q;
    assign ev_data_o  = data_q;
    assign ev_err_o   = err_q;
    assign free_o     = valid_q && ev_ready_i && !err_q;
    assign free_idx_o = idx_q;

endmodule

// File: rtl/trig_latency_buf.sv
// Two-level trigger latency buffer top.
// L0 taps the pipeline at the programmed latency, tags the word with a
// wrapping identifier and files it in the event store; L1/R3 requests
// retrieve events by identifier through a valid/ready output.
module trig_latency_buf #(
    parameter int DATA_W     = 16,
    parameter int PIPE_DEPTH = 128,
    parameter int ID_W       = 8,
    parameter int SLOTS      = 16,
    parameter int LAT_RST    = 8,
    localparam int LAT_W     = $clog2(PIPE_DEPTH) + 1,
    localparam int SLOT_IW   = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bc_i,
    input  logic [DATA_W-1:0] hit_data_i,
    input  logic              lat_we_i,
    input  logic [LAT_W-1:0]  lat_val_i,
    input  logic              l0_i,
    input  logic              req_valid_i,
    input  logic              req_kind_i,
    input  logic [ID_W-1:0]   req_id_i,
    output logic              req_ready_o,
    output logic              ev_valid_o,
    input  logic              ev_ready_i,
    output logic              ev_kind_o,
    output logic [ID_W-1:0]   ev_id_o,
    output logic [DATA_W-1:0] ev_data_o,
    output logic              ev_err_o,
    output logic              ovf_o
);

    logic [DATA_W-1:0]  tap_data;
    logic [LAT_W-1:0]   lat_cur;
    logic [ID_W-1:0]    l0id_q;
    logic               ovf_q;
    logic               store_full;
    logic               look_hit;
    logic [SLOT_IW-1:0] look_idx;
    logic [DATA_W-1:0]  look_data;
    logic               free_fire;
    logic [SLOT_IW-1:0] free_idx;

    tlb_pipeline #(
        .DATA_W (DATA_W),
        .DEPTH  (PIPE_DEPTH),
        .LAT_RST(LAT_RST)
    ) pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bc_i     (bc_i),
        .din_i    (hit_data_i),
        .lat_we_i (lat_we_i),
        .lat_val_i(lat_val_i),
        .tap_o    (tap_data),
        .lat_o    (lat_cur)
    );

    // Identifier generator: one step per L0, accepted or dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) l0id_q <= '0;
        else if (l0_i) l0id_q <= l0id_q + 1'b1;
    end

    // Overflow flag: sticky once an L0 finds the store full.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else if (l0_i && store_full) ovf_q <= 1'b1;
    end

    assign ovf_o = ovf_q;

    tlb_event_store #(
        .DATA_W(DATA_W),
        .ID_W  (ID_W),
        .SLOTS (SLOTS)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (l0_i),
        .alloc_id_i  (l0id_q),
        .alloc_data_i(tap_data),
        .full_o      (store_full),
        .look_id_i   (req_id_i),
        .look_hit_o  (look_hit),
        .look_idx_o  (look_idx),
        .look_data_o (look_data),
        .free_i      (free_fire),
        .free_idx_i  (free_idx)
    );

    tlb_readout #(
        .DATA_W(DATA_W),
        .ID_W  (ID_W),
        .IW    (SLOT_IW)
    ) rdo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid_i),
        .req_kind_i (req_kind_i),
        .req_id_i   (req_id_i),
        .req_ready_o(req_ready_o),
        .look_hit_i (look_hit),
        .look_idx_i (look_idx),
        .look_data_i(look_data),
        .ev_valid_o (ev_valid_o),
        .ev_ready_i (ev_ready_i),
        .ev_kind_o  (ev_kind_o),
        .ev_id_o    (ev_id_o),
        .ev_data_o  (ev_data_o),
        .ev_err_o   (ev_err_o),
        .free_o     (free_fire),
        .free_idx_o (free_idx)
    );

endmodule

// File: rtl/trig_latency_buf_chk.sv
// Protocol and state checks for trig_latency_buf, attached by bind.
module trig_latency_buf_chk #(
    parameter int DATA_W     = 16,
    parameter int PIPE_DEPTH = 128,
    parameter int ID_W       = 8,
    localparam int LAT_W     = $clog2(PIPE_DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l0_i,
    input logic              req_valid_i,
    input logic [ID_W-1:0]   req_id_i,
    input logic              req_ready_o,
    input logic              ev_valid_o,
    input logic              ev_ready_i,
    input logic              ev_kind_o,
    input logic [ID_W-1:0]   ev_id_o,
    input logic [DATA_W-1:0] ev_data_o,
    input logic              ev_err_o,
    input logic              ovf_o,
    input logic [LAT_W-1:0]  lat_q
);

    AST_LAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q < LAT_W'(PIPE_DEPTH)); // R4

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> !req_ready_o); // R10

    AST_EVENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && !ev_ready_i) |=> (ev_valid_o && $stable(ev_data_o) && $stable(ev_id_o)
                                          && $stable(ev_err_o) && $stable(ev_kind_o))); // R10

    AST_EMPTY_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && ev_err_o) |-> (ev_data_o == '0)); // R8

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (ev_valid_o && ev_id_o == $past(req_id_i))); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R6

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(l0_i)); // R6

endmodule

bind trig_latency_buf trig_latency_buf_chk #(
    .DATA_W    (DATA_W),
    .PIPE_DEPTH(PIPE_DEPTH),
    .ID_W      (ID_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .l0_i       (l0_i),
    .req_valid_i(req_valid_i),
    .req_id_i   (req_id_i),
    .req_ready_o(req_ready_o),
    .ev_valid_o (ev_valid_o),
    .ev_ready_i (ev_ready_i),
    .ev_kind_o  (ev_kind_o),
    .ev_id_o    (ev_id_o),
    .ev_data_o  (ev_data_o),
    .ev_err_o   (ev_err_o),
    .ovf_o      (ovf_o),
    .lat_q      (lat_cur)
);

// File: tb/trig_latency_buf_tb_top.sv
// Self-checking bench: small configuration, latency sweep, overflow,
// duplicate identifiers and error responses against an arithmetic model.
module trig_latency_buf_tb_top;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 16;
    localparam int ID_W   = 3;
    localparam int SLOTS  = 4;
    localparam int LATR   = 3;
    localparam int LAT_W  = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bc_i = 1'b0;
    logic [DATA_W-1:0] hit_data_i = '0;
    logic              lat_we_i = 1'b0;
    logic [LAT_W-1:0]  lat_val_i = '0;
    logic              l0_i = 1'b0;
    logic              req_valid_i = 1'b0;
    logic              req_kind_i = 1'b0;
    logic [ID_W-1:0]   req_id_i = '0;
    logic              req_ready_o;
    logic              ev_valid_o;
    logic              ev_ready_i = 1'b0;
    logic              ev_kind_o;
    logic [ID_W-1:0]   ev_id_o;
    logic [DATA_W-1:0] ev_data_o;
    logic              ev_err_o;
    logic              ovf_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int nbc = 0;
    int cur_lat = LATR;
    int id_ctr = 0;
    int last_id = 0;
    bit m_vld [SLOTS];
    int m_id  [SLOTS];
    int m_dat [SLOTS];

    always #10 clk = ~clk;

    trig_latency_buf #(
        .DATA_W    (DATA_W),
        .PIPE_DEPTH(DEPTH),
        .ID_W      (ID_W),
        .SLOTS     (SLOTS),
        .LAT_RST   (LATR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bc_i(bc_i), .hit_data_i(hit_data_i),
        .lat_we_i(lat_we_i), .lat_val_i(lat_val_i), .l0_i(l0_i),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_id_i(req_id_i),
        .req_ready_o(req_ready_o), .ev_valid_o(ev_valid_o), .ev_ready_i(ev_ready_i),
        .ev_kind_o(ev_kind_o), .ev_id_o(ev_id_o), .ev_data_o(ev_data_o),
        .ev_err_o(ev_err_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle of crossing / L0 stimulus, with model update.
    task automatic do_cyc(input bit bc, input bit l0);
        if (l0) begin
            int samp;
            int slot;
            samp = (cur_lat == 0) ? (nbc - DEPTH) : (nbc - cur_lat);
            slot = -1;
            for (int i = SLOTS - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
            if (slot >= 0) begin
                m_vld[slot] = 1'b1;
                m_id[slot]  = id_ctr;
                m_dat[slot] = samp & 16'hFFFF;
            end
            last_id = id_ctr;
            id_ctr  = (id_ctr + 1) % (1 << ID_W);
        end
        bc_i = bc;
        hit_data_i = DATA_W'(nbc);
        l0_i = l0;
        @(posedge clk);
        if (bc) nbc++;
        @(negedge clk);
        bc_i = 1'b0;
        l0_i = 1'b0;
    endtask

    task automatic set_lat(input int v);
        lat_we_i = 1'b1;
        lat_val_i = LAT_W'(v);
        @(posedge clk);
        @(negedge clk);
        lat_we_i = 1'b0;
        if (v < DEPTH) cur_lat = v;
    endtask

    // Request one identifier and drain the response.
    task automatic readout(input int id, input bit kind, input string tag, input bit hold);
        int hit;
        longint held;
        hit = -1;
        for (int i = SLOTS - 1; i >= 0; i--) if (m_vld[i] && m_id[i] == id) hit = i;
        chk("R10 ready before request", req_ready_o, 1);
        req_valid_i = 1'b1;
        req_id_i = ID_W'(id);
        req_kind_i = kind;
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk({tag, " valid"}, ev_valid_o, 1);
        chk({tag, " err"}, ev_err_o, (hit < 0) ? 1 : 0);
        chk({tag, " data"}, ev_data_o, (hit < 0) ? 0 : m_dat[hit]);
        chk({"R7 id ", tag}, ev_id_o, id);
        chk({"R7 kind ", tag}, ev_kind_o, kind);
        if (hold) begin
            held = ev_data_o;
            @(posedge clk);
            @(negedge clk);
            chk("R10 held valid", ev_valid_o, 1);
            chk("R10 held data", ev_data_o, held);
            chk("R10 ready low", req_ready_o, 0);
        end
        ev_ready_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ev_ready_i = 1'b0;
        if (hit >= 0) m_vld[hit] = 1'b0;
        chk("R9 valid drops after handshake", ev_valid_o, 0);
    endtask

    initial begin
        int a;
        for (int i = 0; i < SLOTS; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ev_valid", ev_valid_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 req_ready", req_ready_o, 1);

        // Fill and wrap the pipeline, then a first L0 at reset latency.
        repeat (20) do_cyc(1'b1, 1'b0);
        do_cyc(1'b1, 1'b1);
        readout(last_id, 1'b0, "R3 R5 reset latency", 1'b0);

        // Full latency sweep, with and without a strobe in the L0 cycle.
        for (int lat = 0; lat < DEPTH; lat++) begin
            set_lat(lat);
            repeat (3) do_cyc(1'b1, 1'b0);
            repeat (lat % 3) do_cyc(1'b0, 1'b0); // R2 gaps without strobe
            do_cyc(lat[0], 1'b1);
            do_cyc(1'b0, 1'b0);
            readout(last_id, lat[1], "R2 R3 R5 sweep", (lat % 4) == 0);
        end

        // Out-of-range latency writes are ignored.
        set_lat(5);
        set_lat(16);
        set_lat(23);
        set_lat(31);
        repeat (2) do_cyc(1'b1, 1'b0);
        do_cyc(1'b1, 1'b1);
        readout(last_id, 1'b1, "R4 rejected latency", 1'b0);

        // Overflow, dropped identifiers and duplicates.
        chk("R6 ovf clear before fill", ovf_o, 0);
        a = id_ctr;
        repeat (4) do_cyc(1'b1, 1'b1);
        chk("R6 ovf clear at full", ovf_o, 0);
        repeat (4) do_cyc(1'b1, 1'b1);
        chk("R6 ovf set after drop", ovf_o, 1);
        readout((a + 2) % 8, 1'b0, "R9 free slot", 1'b0);
        readout((a + 2) % 8, 1'b0, "R9 repeat gives error", 1'b0);
        do_cyc(1'b1, 1'b1);
        chk("R5 R11 wrapped id equals first", last_id, a);
        readout(a, 1'b1, "R11 lowest slot wins", 1'b1);
        readout(a, 1'b0, "R11 second copy", 1'b0);
        readout((a + 1) % 8, 1'b0, "R7 drain", 1'b0);
        readout((a + 3) % 8, 1'b0, "R7 drain", 1'b0);
        readout((a + 5) % 8, 1'b1, "R8 no match", 1'b0);
        chk("R6 ovf sticky", ovf_o, 1);

        // Store refills after frees.
        do_cyc(1'b1, 1'b1);
        readout(last_id, 1'b0, "R9 refill after free", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule